// File: doc/BRIEF.md
# Nine-Source Sticky Interrupt Flag Vectoring Unit

This block collects event signals from a sensor-scan peripheral and turns them into nine sticky interrupt flags that share one interrupt request line. Each flag has its own event detector. Two flags capture one selectable line out of a group of four scan outputs. One flag catches the rising edge of a stop signal, and one catches a sequence-start pulse. Two flags watch for entry into a state-machine state that carries a given output bit. Three flags fire at selectable intervals of three external counters: two by a selected counter bit rising, and one by the counter reaching either of two threshold values.

A flag stays set until software clears it. Software can clear flags in bulk through a write-1-to-clear flag register. It can also clear them one at a time by reading the vector register, which names the highest-priority pending enabled flag and clears that flag as a side effect. The request line is the global enable ANDed with any enabled pending flag. The sequencer, the counters and the sensing front end sit outside the block, and only their event signals enter it.

Top module: `scan_irq_vectorer`

## Requirements
- R1: Flag 0 sets when `scan_out[scan_lo_sel]` is 1. Flag 8 sets when `scan_out[4 + scan_hi_sel]` is 1. A line that is not selected has no effect.
- R2: Flag 1 sets only on a 0-to-1 transition of `stop_in`. Holding `stop_in` high does not set the flag again after it is cleared.
- R3: Flag 2 sets in any cycle where `seq_start` is 1.
- R4: Flag 5 sets when `psm_state[6]` changes from 0 to 1 between consecutive cycles. Flag 6 does the same for `psm_state[7]`. Staying in a state whose bit is already 1, or falling to 0, sets nothing.
- R5: Flag 4 sets when bit `span_sel` of `span_cnt` goes from 0 to 1 between consecutive cycles. Flag 7 does the same for bit `base_sel` of `base_cnt`.
- R6: Flag 3 sets when `tick_cnt` takes a new value, different from the previous cycle, that equals `thr_a` or `thr_b`. A value held unchanged does not set it again.
- R7: Flags are sticky. Hardware never clears a flag except on a software clear. A set flag becomes visible one clock after its event.
- R8: Writing to address 0 (`bus_addr`=0) clears each flag whose bit n of `bus_wdata` is 1. Bits written as 0 leave their flags unchanged. Reading address 0 returns flag n in bit n.
- R9: Address 1 returns the vector code. The code is 0 when no flag is both set and enabled. Otherwise it is 2×(n+1) for the lowest-numbered set and enabled flag n. Disabled flags are skipped.
- R10: A read strobe (`bus_rd`) at address 1 clears only the flag that the vector reports. When the vector is 0, the read clears nothing.
- R11: When a set event and a clear for the same flag occur in the same cycle, the flag ends up set.
- R12: `irq` is 1 exactly when `gie` is 1 and at least one flag is both set and enabled by `flag_en`.
- R13: After synchronous reset, all flags are 0, the vector is 0, `irq` is 0, and all edge-detector history is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_out | input | 8 | Scan outputs; lines 3:0 feed flag 0, lines 7:4 feed flag 8 |
| scan_lo_sel | input | 2 | Line select within the low group |
| scan_hi_sel | input | 2 | Line select within the high group |
| stop_in | input | 1 | Sequencer stop level (rising edge sets flag 1) |
| seq_start | input | 1 | Sequence-start pulse (sets flag 2) |
| psm_state | input | STATE_W | State-machine output bits |
| tick_cnt | input | CNT_W | Counter for flag 3 |
| thr_a | input | CNT_W | First threshold for flag 3 |
| thr_b | input | CNT_W | Second threshold for flag 3 |
| span_cnt | input | CNT_W | Counter for flag 4 |
| span_sel | input | SEL_W | Bit select for flag 4 |
| base_cnt | input | CNT_W | Counter for flag 7 |
| base_sel | input | SEL_W | Bit select for flag 7 |
| flag_en | input | 9 | Per-flag enables |
| gie | input | 1 | Global interrupt enable |
| bus_addr | input | 1 | Register select: 0 flags, 1 vector |
| bus_rd | input | 1 | Read strobe (side effect at address 1) |
| bus_wr | input | 1 | Write strobe (address 0 only) |
| bus_wdata | input | DATA_W | Write data (clear mask) |
| bus_rdata | output | DATA_W | Read data for the selected address |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench first clears a flag while `stop_in` or the watched state bit is still high. A detector that sensed a level instead of a transition would set the flag straight back. It then reads the vector with several flags pending, some of them disabled. A wrong priority order or a mask applied in the wrong place would report the wrong code, and a clear aimed at the wrong flag would leave the next read showing a stale code. It also strikes a clear and a set event in the same cycle; a design that let the clear win would lose the event. Finally, it performs a vector read while nothing enabled is pending, so a design that cleared flag 0 or any masked flag on that read would show up.

// File: rtl/ivu_pkg.sv
package ivu_pkg;

    localparam int NUM_FLAGS  = 9;
    localparam int FLAG_IDX_W = $clog2(NUM_FLAGS);
    localparam int VEC_W      = $clog2(2 * NUM_FLAGS + 1);

    // Bit positions of the flags in the flag register; the order is the priority.
    localparam int F_SCAN_LO = 0;
    localparam int F_STOP    = 1;
    localparam int F_START   = 2;
    localparam int F_THRESH  = 3;
    localparam int F_SPAN    = 4;
    localparam int F_ST_A    = 5;
    localparam int F_ST_B    = 6;
    localparam int F_BASE    = 7;
    localparam int F_SCAN_HI = 8;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef enum logic {
        REG_FLAGS  = 1'b0,
        REG_VECTOR = 1'b1
    } reg_sel_e;

    typedef enum logic [1:0] {
        TAP_THRESHOLD = 2'd0,
        TAP_BIT_RISE  = 2'd1
    } tap_mode_e;

    typedef struct packed {
        logic                  hit;
        logic [FLAG_IDX_W-1:0] idx;
    } prio_t;

    typedef struct packed {
        flag_vec_t sw_clr;
        flag_vec_t rd_clr;
    } clr_req_t;

    function automatic logic [VEC_W-1:0] encode_vector(input prio_t p);
        logic [VEC_W-1:0] code;
        code = '0;
        if (p.hit) begin
            code = VEC_W'((32'(p.idx) + 1) * 2);
        end
        return code;
    endfunction

    function automatic flag_vec_t idx_onehot(input prio_t p);
        flag_vec_t oh;
        oh = '0;
        if (p.hit) begin
            oh = flag_vec_t'(1) << p.idx;
        end
        return oh;
    endfunction

endpackage

// File: rtl/ivu_event_front.sv
module ivu_event_front #(
    parameter int STATE_W  = 8,
    parameter int ST_BIT_A = 6,
    parameter int ST_BIT_B = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         scan_out,
    input  logic [1:0]         scan_lo_sel,
    input  logic [1:0]         scan_hi_sel,
    input  logic               stop_in,
    input  logic               seq_start,
    input  logic [STATE_W-1:0] psm_state,
    output logic [1:0]         scan_ev,
    output logic               stop_ev,
    output logic               start_ev,
    output logic [1:0]         state_ev
);

    localparam int GROUPS    = 2;
    localparam int GROUP_LEN = 4;

    logic [GROUPS-1:0][1:0] grp_sel;
    assign grp_sel[0] = scan_lo_sel;
    assign grp_sel[1] = scan_hi_sel;

    // Selectable-output capture: one line of each group of four.
    for (genvar g = 0; g < GROUPS; g++) begin : g_scan_grp
        logic [GROUP_LEN-1:0] lines;
        assign lines      = scan_out[g*GROUP_LEN +: GROUP_LEN];
        assign scan_ev[g] = lines[grp_sel[g]];
    end

    // Rising-edge detection on the stop level.
    logic stop_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b0;
        end else begin
            stop_q <= stop_in;
        end
    end
    assign stop_ev  = stop_in & ~stop_q;
    assign start_ev = seq_start;

    // Entry into a state carrying a watched bit.
    logic [1:0] watched;
    for (genvar w = 0; w < 2; w++) begin : g_watch
        localparam int WB = (w == 0) ? ST_BIT_A : ST_BIT_B;
        logic bit_q;
        assign watched[w] = psm_state[WB];
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= watched[w];
            end
        end
        assign state_ev[w] = watched[w] & ~bit_q;
    end

    logic unused_state;
    assign unused_state = ^psm_state;

endmodule

// File: rtl/ivu_count_tap.sv
module ivu_count_tap #(
    parameter int                 CNT_W = 16,
    parameter ivu_pkg::tap_mode_e MODE  = ivu_pkg::TAP_BIT_RISE,
    localparam int                SEL_W = $clog2(CNT_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic [CNT_W-1:0] thr_a,
    input  logic [CNT_W-1:0] thr_b,
    output logic             tap_ev
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt;
        end
    end

    if (MODE == ivu_pkg::TAP_THRESHOLD) begin : g_thresh
        logic changed;
        logic match;
        assign changed = (cnt != cnt_q);
        assign match   = (cnt == thr_a) || (cnt == thr_b);
        assign tap_ev  = changed & match;
        logic unused_sel;
        assign unused_sel = ^bit_sel;
    end else begin : g_bit_rise
        assign tap_ev = cnt[bit_sel] & ~cnt_q[bit_sel];
        logic unused_thr;
        assign unused_thr = ^{thr_a, thr_b};
    end

endmodule

// File: rtl/ivu_flag_bank.sv
module ivu_flag_bank
    import ivu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_ev,
    input  clr_req_t  clr_req,
    output flag_vec_t flags,
    output flag_vec_t clr_any
);

    assign clr_any = clr_req.sw_clr | clr_req.rd_clr;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (set_ev[i]) begin
                flag_q <= 1'b1;          // a new event outranks a clear
            end else if (clr_any[i]) begin
                flag_q <= 1'b0;
            end
        end
        assign flags[i] = flag_q;
    end

endmodule

// File: rtl/ivu_prio_vec.sv
module ivu_prio_vec
    import ivu_pkg::*;
(
    input  flag_vec_t        flags,
    input  flag_vec_t        enables,
    output prio_t            winner,
    output logic [VEC_W-1:0] vec_code
);

    flag_vec_t pend;
    assign pend = flags & enables;

    always_comb begin
        winner = '0;
        for (int i = NUM_FLAGS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                winner.hit = 1'b1;
                winner.idx = FLAG_IDX_W'(i);
            end
        end
    end

    assign vec_code = encode_vector(winner);

endmodule

// File: rtl/scan_irq_vectorer.sv
module scan_irq_vectorer
    import ivu_pkg::*;
#(
    parameter int  CNT_W    = 16,
    parameter int  STATE_W  = 8,
    parameter int  DATA_W   = 16,
    parameter int  ST_BIT_A = 6,
    parameter int  ST_BIT_B = 7,
    localparam int SEL_W    = $clog2(CNT_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           scan_out,
    input  logic [1:0]           scan_lo_sel,
    input  logic [1:0]           scan_hi_sel,
    input  logic                 stop_in,
    input  logic                 seq_start,
    input  logic [STATE_W-1:0]   psm_state,
    input  logic [CNT_W-1:0]     tick_cnt,
    input  logic [CNT_W-1:0]     thr_a,
    input  logic [CNT_W-1:0]     thr_b,
    input  logic [CNT_W-1:0]     span_cnt,
    input  logic [SEL_W-1:0]     span_sel,
    input  logic [CNT_W-1:0]     base_cnt,
    input  logic [SEL_W-1:0]     base_sel,
    input  logic [NUM_FLAGS-1:0] flag_en,
    input  logic                 gie,
    input  logic                 bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq
);

    logic [1:0]       scan_ev;
    logic             stop_ev;
    logic             start_ev;
    logic [1:0]       state_ev;
    logic             thresh_ev;
    logic             span_ev;
    logic             base_ev;
    flag_vec_t        set_ev;
    flag_vec_t        flag_q;
    flag_vec_t        clr_vec;
    clr_req_t         clr_req;
    prio_t            winner;
    logic [VEC_W-1:0] vec_code;
    reg_sel_e         sel;

    ivu_event_front #(
        .STATE_W  (STATE_W),
        .ST_BIT_A (ST_BIT_A),
        .ST_BIT_B (ST_BIT_B)
    ) i_front (
        .clk         (clk),
        .rst         (rst),
        .scan_out    (scan_out),
        .scan_lo_sel (scan_lo_sel),
        .scan_hi_sel (scan_hi_sel),
        .stop_in     (stop_in),
        .seq_start   (seq_start),
        .psm_state   (psm_state),
        .scan_ev     (scan_ev),
        .stop_ev     (stop_ev),
        .start_ev    (start_ev),
        .state_ev    (state_ev)
    );

    ivu_count_tap #(.CNT_W(CNT_W), .MODE(TAP_THRESHOLD)) i_tap_thresh (
        .clk     (clk),
        .rst     (rst),
        .cnt     (tick_cnt),
        .bit_sel ('0),
        .thr_a   (thr_a),
        .thr_b   (thr_b),
        .tap_ev  (thresh_ev)
    );

    ivu_count_tap #(.CNT_W(CNT_W), .MODE(TAP_BIT_RISE)) i_tap_span (
        .clk     (clk),
        .rst     (rst),
        .cnt     (span_cnt),
        .bit_sel (span_sel),
        .thr_a   ('0),
        .thr_b   ('0),
        .tap_ev  (span_ev)
    );

    ivu_count_tap #(.CNT_W(CNT_W), .MODE(TAP_BIT_RISE)) i_tap_base (
        .clk     (clk),
        .rst     (rst),
        .cnt     (base_cnt),
        .bit_sel (base_sel),
        .thr_a   ('0),
        .thr_b   ('0),
        .tap_ev  (base_ev)
    );

    always_comb begin
        set_ev            = '0;
        set_ev[F_SCAN_LO] = scan_ev[0];
        set_ev[F_STOP]    = stop_ev;
        set_ev[F_START]   = start_ev;
        set_ev[F_THRESH]  = thresh_ev;
        set_ev[F_SPAN]    = span_ev;
        set_ev[F_ST_A]    = state_ev[0];
        set_ev[F_ST_B]    = state_ev[1];
        set_ev[F_BASE]    = base_ev;
        set_ev[F_SCAN_HI] = scan_ev[1];
    end

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        clr_req = '0;
        if (bus_wr && sel == REG_FLAGS) begin
            clr_req.sw_clr = bus_wdata[NUM_FLAGS-1:0];
        end
        if (bus_rd && sel == REG_VECTOR) begin
            clr_req.rd_clr = idx_onehot(winner);
        end
    end

    ivu_flag_bank i_bank (
        .clk     (clk),
        .rst     (rst),
        .set_ev  (set_ev),
        .clr_req (clr_req),
        .flags   (flag_q),
        .clr_any (clr_vec)
    );

    ivu_prio_vec i_prio (
        .flags    (flag_q),
        .enables  (flag_en),
        .winner   (winner),
        .vec_code (vec_code)
    );

    always_comb begin
        unique case (sel)
            REG_FLAGS:  bus_rdata = DATA_W'(flag_q);
            REG_VECTOR: bus_rdata = DATA_W'(vec_code);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = gie & (|(flag_q & flag_en));

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/ivu_checker.sv
module ivu_checker
    import ivu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             stop_in,
    input logic             seq_start,
    input logic             gie,
    input flag_vec_t        flag_en,
    input flag_vec_t        flags,
    input flag_vec_t        clr,
    input logic [VEC_W-1:0] vec,
    input logic             irq
);

    // R2
    stop_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_in) |=> flags[F_STOP]);

    // R3
    seq_start_chk: assert property (@(posedge clk) disable iff (rst)
        seq_start |=> flags[F_START]);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(flags) & ~$past(clr)) & ~flags) == '0);

    // R9
    vec_form_chk: assert property (@(posedge clk) disable iff (rst)
        !vec[0] && (32'(vec) <= 2 * NUM_FLAGS));

    // R9
    vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (vec == '0) == ((flags & flag_en) == '0));

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> gie);

    // R12
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (gie && vec != '0) |-> irq);

endmodule

bind scan_irq_vectorer ivu_checker i_ivu_checker (
    .clk       (clk),
    .rst       (rst),
    .stop_in   (stop_in),
    .seq_start (seq_start),
    .gie       (gie),
    .flag_en   (flag_en),
    .flags     (flag_q),
    .clr       (clr_vec),
    .vec       (vec_code),
    .irq       (irq)
);

// File: tb/test_scan_irq_vectorer.sv
`timescale 1ns/100ps
module test_scan_irq_vectorer;

    localparam int CNT_W = 16;
    localparam int SEL_W = $clog2(CNT_W);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       scan_out = '0;
    logic [1:0]       scan_lo_sel = '0;
    logic [1:0]       scan_hi_sel = '0;
    logic             stop_in = 1'b0;
    logic             seq_start = 1'b0;
    logic [7:0]       psm_state = '0;
    logic [CNT_W-1:0] tick_cnt = '0;
    logic [CNT_W-1:0] thr_a = 16'd10;
    logic [CNT_W-1:0] thr_b = 16'd20;
    logic [CNT_W-1:0] span_cnt = '0;
    logic [SEL_W-1:0] span_sel = '0;
    logic [CNT_W-1:0] base_cnt = '0;
    logic [SEL_W-1:0] base_sel = '0;
    logic [8:0]       flag_en = 9'h1FF;
    logic             gie = 1'b1;
    logic             bus_addr = 1'b0;
    logic             bus_rd = 1'b0;
    logic             bus_wr = 1'b0;
    logic [15:0]      bus_wdata = '0;
    logic [15:0]      bus_rdata;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scan_irq_vectorer i_scan_irq_vectorer (
        .clk(clk), .rst(rst), .scan_out(scan_out), .scan_lo_sel(scan_lo_sel),
        .scan_hi_sel(scan_hi_sel), .stop_in(stop_in), .seq_start(seq_start),
        .psm_state(psm_state), .tick_cnt(tick_cnt), .thr_a(thr_a), .thr_b(thr_b),
        .span_cnt(span_cnt), .span_sel(span_sel), .base_cnt(base_cnt),
        .base_sel(base_sel), .flag_en(flag_en), .gie(gie), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic read_flags(output int v);
        bus_addr = 1'b0;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic read_vec(output int v);
        bus_addr = 1'b1;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic write_clear(input int mask);
        bus_addr  = 1'b0;
        bus_wr    = 1'b1;
        bus_wdata = 16'(mask);
        tick();
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic vec_read_strobe(output int v);
        bus_addr = 1'b1;
        bus_rd   = 1'b1;
        #1;
        v = int'(bus_rdata);
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        read_flags(v);
        check("R13", "flags after reset", v, 0);
        read_vec(v);
        check("R13", "vector after reset", v, 0);
        check("R13", "irq after reset", int'(irq), 0);
    endtask

    task automatic t_scan_capture();
        int v;
        scan_lo_sel = 2'd2;
        scan_out = 8'b0000_0010;
        tick();
        scan_out = '0;
        read_flags(v);
        check("R1", "unselected low line", v, 0);
        scan_out = 8'b0000_0100;
        tick();
        scan_out = '0;
        read_flags(v);
        check("R1", "selected low line sets flag 0", v, 9'h001);
        repeat (3) tick();
        read_flags(v);
        check("R7", "flag 0 holds with source idle", v, 9'h001);
        write_clear(9'h1FF);
        scan_hi_sel = 2'd1;
        scan_out = 8'b0001_0000;
        tick();
        scan_out = '0;
        read_flags(v);
        check("R1", "unselected high line", v, 0);
        scan_out = 8'b0010_0000;
        tick();
        scan_out = '0;
        read_flags(v);
        check("R1", "selected high line sets flag 8", v, 9'h100);
        write_clear(9'h1FF);
    endtask

    task automatic t_stop_edge();
        int v;
        stop_in = 1'b1;
        tick();
        read_flags(v);
        check("R2", "stop rise sets flag 1", v, 9'h002);
        write_clear(9'h002);
        repeat (2) tick();
        read_flags(v);
        check("R2", "steady stop high does not re-set", v, 0);
        stop_in = 1'b0;
        tick();
        stop_in = 1'b1;
        tick();
        read_flags(v);
        check("R2", "second rise sets flag 1", v, 9'h002);
        stop_in = 1'b0;
        write_clear(9'h1FF);
    endtask

    task automatic t_seq_start();
        int v;
        seq_start = 1'b1;
        tick();
        seq_start = 1'b0;
        read_flags(v);
        check("R3", "start pulse sets flag 2", v, 9'h004);
        write_clear(9'h1FF);
    endtask

    task automatic t_state_entry();
        int v;
        psm_state = 8'h40;
        tick();
        read_flags(v);
        check("R4", "entry to bit6 state sets flag 5", v, 9'h020);
        write_clear(9'h1FF);
        psm_state = 8'h41;
        repeat (2) tick();
        read_flags(v);
        check("R4", "staying with bit6 high sets nothing", v, 0);
        psm_state = 8'hC1;
        tick();
        read_flags(v);
        check("R4", "entry to bit7 state sets flag 6 only", v, 9'h040);
        psm_state = 8'h00;
        tick();
        read_flags(v);
        check("R4", "falling bits set nothing new", v, 9'h040);
        write_clear(9'h1FF);
    endtask

    task automatic t_counter_bits();
        int v;
        span_sel = 4'd2;
        span_cnt = 16'd3;
        tick();
        read_flags(v);
        check("R5", "span 0->3 no rise on bit2", v, 0);
        span_cnt = 16'd4;
        tick();
        read_flags(v);
        check("R5", "span 3->4 bit2 rises sets flag 4", v, 9'h010);
        write_clear(9'h1FF);
        span_cnt = 16'd5;
        tick();
        read_flags(v);
        check("R5", "span 4->5 bit2 steady", v, 0);
        span_cnt = 16'd0;
        base_sel = 4'd0;
        base_cnt = 16'd1;
        tick();
        read_flags(v);
        check("R5", "base bit0 rise sets flag 7", v, 9'h080);
        base_cnt = 16'd0;
        write_clear(9'h1FF);
    endtask

    task automatic t_counter_thresh();
        int v;
        tick_cnt = 16'd9;
        tick();
        read_flags(v);
        check("R6", "non-matching count", v, 0);
        tick_cnt = 16'd10;
        tick();
        read_flags(v);
        check("R6", "count reaches thr_a sets flag 3", v, 9'h008);
        write_clear(9'h1FF);
        tick();
        read_flags(v);
        check("R6", "held matching count no re-set", v, 0);
        tick_cnt = 16'd20;
        tick();
        read_flags(v);
        check("R6", "count reaches thr_b sets flag 3", v, 9'h008);
        tick_cnt = 16'd0;
        write_clear(9'h1FF);
    endtask

    task automatic t_w1c_and_collision();
        int v;
        seq_start = 1'b1;
        stop_in   = 1'b1;
        tick();
        seq_start = 1'b0;
        stop_in   = 1'b0;
        write_clear(9'h004);
        read_flags(v);
        check("R8", "w1c clears only written bit", v, 9'h002);
        seq_start = 1'b1;
        bus_addr  = 1'b0;
        bus_wr    = 1'b1;
        bus_wdata = 16'h0006;
        tick();
        bus_wr    = 1'b0;
        seq_start = 1'b0;
        read_flags(v);
        check("R11", "set beats clear in same cycle", v, 9'h004);
        write_clear(9'h1FF);
    endtask

    task automatic t_vector_and_irq();
        int v;
        scan_hi_sel = 2'd0;
        scan_out    = 8'h10;
        psm_state   = 8'h40;
        tick_cnt    = 16'd10;
        tick();
        scan_out  = '0;
        psm_state = '0;
        tick();
        read_flags(v);
        check("R9", "three flags pending", v, 9'h128);
        check("R12", "irq with enabled pending", int'(irq), 1);
        read_vec(v);
        check("R9", "vector names flag 3", v, 8);
        gie = 1'b0;
        #1;
        check("R12", "irq low with gie off", int'(irq), 0);
        gie = 1'b1;
        flag_en = 9'h1F7;
        read_vec(v);
        check("R9", "disabled flag 3 skipped", v, 12);
        flag_en = 9'h1FF;
        vec_read_strobe(v);
        check("R10", "first vector read", v, 8);
        read_flags(v);
        check("R10", "read cleared flag 3 only", v, 9'h120);
        vec_read_strobe(v);
        check("R10", "second vector read", v, 12);
        vec_read_strobe(v);
        check("R10", "third vector read", v, 18);
        read_flags(v);
        check("R10", "all cleared by reads", v, 0);
        read_vec(v);
        check("R9", "vector idle", v, 0);
        check("R12", "irq idle", int'(irq), 0);
        tick_cnt = 16'd0;
        seq_start = 1'b1;
        tick();
        seq_start = 1'b0;
        flag_en = 9'h000;
        #1;
        check("R12", "irq low when flag disabled", int'(irq), 0);
        vec_read_strobe(v);
        check("R10", "zero vector with masked flag", v, 0);
        read_flags(v);
        check("R10", "zero-vector read clears nothing", v, 9'h004);
        flag_en = 9'h1FF;
        write_clear(9'h1FF);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_scan_capture();
        t_stop_edge();
        t_seq_start();
        t_state_entry();
        t_counter_bits();
        t_counter_thresh();
        t_w1c_and_collision();
        t_vector_and_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule